// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Generation

This block performs the eight single-bit shift and rotate operations of a classic 8-bit CPU datapath. The inputs are an operand, the current carry flag and a 3-bit operation code. The outputs are the shifted result and a complete 8-bit flag byte. The block has no part in writing the result back to a register or to memory, in fetching instructions or in decoding prefixes. A separate sequencer sets the bus timing.

The three low bits of the opcode select the operation. Even codes shift toward the most significant bit, and odd codes shift toward bit 0. Every operation builds the whole flag byte again from the result and the bit that was shifted out. No earlier flag survives, apart from its use as the carry input of the two through-carry rotates.

The opcode, operand and carry are captured when `in_valid` is high. The result and flags appear one clock later, together with a single-cycle `out_done` pulse, and they hold their values until the next capture. The parameter `REG_OUT` = 0 removes this register and gives a purely combinational path.

Top module: `shrot_unit`

## Requirements
- R1: Opcode 0 rotates left circularly: old bit 7 moves into bit 0.
- R2: Opcode 1 rotates right circularly: old bit 0 moves into bit 7.
- R3: Opcode 2 rotates left through the carry, with the incoming carry entering bit 0. Opcode 3 rotates right through the carry, with the incoming carry entering bit 7.
- R4: Opcode 4 shifts left with 0 entering bit 0. Opcode 5 shifts right and leaves bit 7 unchanged.
- R5: Opcode 6 shifts left with 1 entering bit 0. Opcode 7 shifts right with 0 entering bit 7.
- R6: Flag bit 0 (carry) is the bit shifted out. For even opcodes this is old bit 7; for odd opcodes it is old bit 0.
- R7: Flag bit 7 (sign) copies result bit 7, flag bit 5 copies result bit 5, and flag bit 3 copies result bit 3.
- R8: Flag bit 6 (zero) is 1 exactly when the result is 0x00.
- R9: Flag bit 2 (parity) is 1 exactly when the result has an even number of ones.
- R10: Flag bit 4 (half-carry) and flag bit 1 (subtract) are always 0.
- R11: A capture with `in_valid` gives result, flags and a one-cycle `out_done` on the next clock. Without `in_valid`, `out_done` is 0 and result and flags hold.
- R12: While `rst_n` is low, `out_done`, `out_data` and `out_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for opcode, operand and carry |
| in_op | input | 3 | Operation code |
| in_data | input | DATA_W | Operand |
| in_carry | input | 1 | Incoming carry flag |
| out_done | output | 1 | Result valid pulse, one clock after capture |
| out_data | output | DATA_W | Shifted result |
| out_flags | output | 8 | Flag byte {S,Z,F5,H,F3,PV,N,C} |

## Verification
Several properties are checked on every cycle. Half-carry and subtract must stay clear. Zero and parity must agree with the registered result. Carry must equal the bit shifted out of the captured operand. The done pulse must track the strobe one cycle later, and the outputs must hold when idle. The bench alone can show that each opcode supplies the correct fill bit, because this depends on the incoming carry. It applies every operand with both carry values under every opcode and compares against an independent model.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   localparam int FLAG_W = 8;
   localparam int FB_C  = 0;
   localparam int FB_N  = 1;
   localparam int FB_PV = 2;
   localparam int FB_F3 = 3;
   localparam int FB_H  = 4;
   localparam int FB_F5 = 5;
   localparam int FB_Z  = 6;
   localparam int FB_S  = 7;

   typedef enum logic [2:0] {
      OP_ROTL_CIRC = 3'd0,
      OP_ROTR_CIRC = 3'd1,
      OP_ROTL_CARRY = 3'd2,
      OP_ROTR_CARRY = 3'd3,
      OP_SHL_ZERO  = 3'd4,
      OP_SHR_SIGN  = 3'd5,
      OP_SHL_ONE   = 3'd6,
      OP_SHR_ZERO  = 3'd7
   } shrot_op_e;
endpackage

// File: rtl/shrot_core.sv
module shrot_core
   import shrot_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic              cin,
   output logic [DATA_W-1:0] y,
   output logic              cout
);
   localparam int MSB = DATA_W - 1;

   logic fill;
   logic go_right;

   // R1 R2 R3 R4 R5: pick the bit that enters the vacated end
   always_comb begin
      go_right = op[0];
      unique case (shrot_op_e'(op))
         OP_ROTL_CIRC:  fill = a[MSB];
         OP_ROTR_CIRC:  fill = a[0];
         OP_ROTL_CARRY: fill = cin;
         OP_ROTR_CARRY: fill = cin;
         OP_SHL_ZERO:   fill = 1'b0;
         OP_SHR_SIGN:   fill = a[MSB];
         OP_SHL_ONE:    fill = 1'b1;
         OP_SHR_ZERO:   fill = 1'b0;
         default:       fill = 1'b0;
      endcase
   end

   // R6: the bit leaving the word becomes the new carry
   always_comb begin
      if (go_right) begin
         y    = {fill, a[MSB:1]};
         cout = a[0];
      end else begin
         y    = {a[MSB-1:0], fill};
         cout = a[MSB];
      end
   end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
   import shrot_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              cout,
   output logic [FLAG_W-1:0] flags
);
   always_comb begin
      flags        = '0;                 // R10: H and N stay clear
      flags[FB_C]  = cout;               // R6
      flags[FB_S]  = res[DATA_W-1];      // R7
      flags[FB_F5] = res[5];
      flags[FB_F3] = res[3];
      flags[FB_Z]  = (res == '0);        // R8
      flags[FB_PV] = ~(^res);            // R9
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_carry,
   output logic              out_done,
   output logic [DATA_W-1:0] out_data,
   output logic [7:0]        out_flags
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 8) begin : g_bad_width
      $error("shrot_unit: DATA_W must be at least 8");
   end

   logic [DATA_W-1:0] core_y;
   logic              core_c;
   logic [FLAG_W-1:0] core_f;

   shrot_core #(.DATA_W(DATA_W)) u_core (
      .op   (in_op),
      .a    (in_data),
      .cin  (in_carry),
      .y    (core_y),
      .cout (core_c)
   );

   shrot_flags #(.DATA_W(DATA_W)) u_flags (
      .res   (core_y),
      .cout  (core_c),
      .flags (core_f)
   );

   if (REG_OUT) begin : g_reg
      logic              done_q;
      logic [DATA_W-1:0] data_q;
      logic [FLAG_W-1:0] flag_q;

      // R11 R12
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            data_q <= '0;
            flag_q <= '0;
         end else begin
            done_q <= in_valid;
            if (in_valid) begin
               data_q <= core_y;
               flag_q <= core_f;
            end
         end
      end

      assign out_done  = done_q;
      assign out_data  = data_q;
      assign out_flags = flag_q;

      // R11
      done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_done);
      // R11
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_done && $stable(out_data) && $stable(out_flags)));
      // R6
      carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_flags[FB_C] ==
            ($past(in_op[0]) ? $past(in_data[0]) : $past(in_data[MSB])));
   end else begin : g_comb
      assign out_done  = in_valid;
      assign out_data  = core_y;
      assign out_flags = core_f;
   end

   // R10
   hn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (!out_flags[FB_H] && !out_flags[FB_N]));
   // R8
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (out_flags[FB_Z] == (out_data == '0)));
   // R9
   parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (out_flags[FB_PV] == ($countones(out_data) % 2 == 0)));
   // R7
   copy_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (out_flags[FB_S] == out_data[MSB] &&
                    out_flags[FB_F5] == out_data[5] &&
                    out_flags[FB_F3] == out_data[3]));
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_op = '0;
   logic [7:0] in_data = '0;
   logic       in_carry = 1'b0;
   logic       out_done;
   logic [7:0] out_data;
   logic [7:0] out_flags;

   int nchk = 0;
   int nfail = 0;
   int nvec = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   shrot_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_data(in_data), .in_carry(in_carry), .out_done(out_done),
      .out_data(out_data), .out_flags(out_flags)
   );

   // Behavioural reference: returns {carry, result}
   function automatic int ref_shift(int op, int d, int c);
      int r, co;
      case (op)
         0: begin co = d / 128; r = (d * 2) % 256 + co; end
         1: begin co = d % 2; r = d / 2 + co * 128; end
         2: begin co = d / 128; r = (d * 2) % 256 + c; end
         3: begin co = d % 2; r = d / 2 + c * 128; end
         4: begin co = d / 128; r = (d * 2) % 256; end
         5: begin co = d % 2; r = d / 2 + (d / 128) * 128; end
         6: begin co = d / 128; r = (d * 2) % 256 + 1; end
         default: begin co = d % 2; r = d / 2; end
      endcase
      return co * 256 + r;
   endfunction

   function automatic string op_req(int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         4, 5: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare(int op, int d, int c);
      int m, r, co, ones;
      m = ref_shift(op, d, c);
      r = m % 256;
      co = m / 256;
      ones = 0;
      for (int b = 0; b < 8; b++) ones += (r >> b) & 1;
      chk(out_done === 1'b1, "R11", int'(out_done), 1);
      chk(out_data === 8'(r), op_req(op), int'(out_data), r);
      chk(out_flags[0] === co[0], "R6", int'(out_flags[0]), co);
      chk(out_flags[7] === r[7] && out_flags[5] === r[5] && out_flags[3] === r[3],
          "R7", int'(out_flags), r);
      chk(out_flags[6] === (r == 0), "R8", int'(out_flags[6]), int'(r == 0));
      chk(out_flags[2] === (ones % 2 == 0), "R9", int'(out_flags[2]), int'(ones % 2 == 0));
      chk(out_flags[4] === 1'b0 && out_flags[1] === 1'b0, "R10", int'(out_flags), 0);
   endtask

   initial begin
      int pop, pd, pc;
      bit have_prev;
      logic [7:0] hold_d, hold_f;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(out_done === 1'b0 && out_data === 8'h00 && out_flags === 8'h00,
          "R12", int'({out_done, out_data, out_flags}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      have_prev = 1'b0;
      for (int op = 0; op < 8; op++) begin
         for (int c = 0; c < 2; c++) begin
            for (int d = 0; d < 256; d++) begin
               if (have_prev) compare(pop, pd, pc);
               in_valid = 1'b1;
               in_op = 3'(op);
               in_data = 8'(d);
               in_carry = c[0];
               pop = op; pd = d; pc = c; have_prev = 1'b1;
               nvec++;
               @(negedge clk);
            end
         end
      end
      compare(pop, pd, pc);
      // R11: idle cycles with changing inputs must not disturb outputs
      in_valid = 1'b0;
      hold_d = out_data;
      hold_f = out_flags;
      for (int k = 0; k < 4; k++) begin
         in_data = 8'(k * 37 + 5);
         in_op = 3'(k);
         in_carry = ~in_carry;
         @(negedge clk);
         chk(out_done === 1'b0 && out_data === hold_d && out_flags === hold_f,
             "R11", int'({out_done, out_data, out_flags}), int'({1'b0, hold_d, hold_f}));
      end
      // R12: reset again clears outputs
      rst_n = 1'b0;
      #1;
      chk(out_done === 1'b0 && out_data === 8'h00 && out_flags === 8'h00,
          "R12", int'({out_done, out_data, out_flags}), 0);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule